// File: doc/BRIEF.md
# CAN Frame Serializer with Bit Stuffing

This block turns one CAN 2.0B data or remote frame into a serial bit stream, one bit for each pulse of an external bit strobe. A caller presents the identifier, the frame-format and remote flags, the data length code and up to eight payload bytes, then pulses a start request. The block captures those inputs. It then drives the start bit, the arbitration and control fields and the payload. It appends the 15-bit CRC, with stuff bits inserted where the protocol needs them, and closes with the fixed recessive trailer.

Bit timing stays outside the block. A bit-timing unit supplies the strobe and the bus level it sampled. The serializer uses that read-back level for two things. During the arbitration field it stops the frame if another node has overwritten a recessive bit. In the acknowledge slot it records whether a receiver drove the slot dominant. A one-cycle completion pulse marks the end of the trailer.

Top module: `can_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txBit` is recessive (1) and `busy` is low. `done`, `ackSeen` and `arbLost` are low after reset.
- R2: A standard frame (`ideFlag`=0) is sent as: one dominant start bit, `ident[10:0]` MSB first, the RTR bit (0 for data, 1 for remote), two dominant bits (IDE and reserved), then `dlc` MSB first.
- R3: An extended frame (`ideFlag`=1) is sent as: start bit, `ident[28:18]` MSB first, two recessive bits (SRR, IDE), `ident[17:0]` MSB first, the RTR bit, two dominant reserved bits, then `dlc` MSB first.
- R4: A data frame carries min(`dlc`, 8) bytes taken from `payload[63:56]` downward, each byte MSB first. A remote frame carries no data bytes, whatever `dlc` holds.
- R5: The 15-bit CRC follows the last data bit, or the DLC when no data is sent, MSB first. The CRC uses the polynomial x^15+x^14+x^10+x^8+x^7+x^4+x^3+1 with a zero start value and covers the start bit through the last data bit.
- R6: From the start bit through the last CRC bit, after five equal bits in a row the next bit sent is their complement. The run counts earlier stuff bits, and a stuff bit can follow the last CRC bit. Stuff bits do not enter the CRC.
- R7: After the CRC (and any final stuff bit), the block sends 13 recessive bits: CRC delimiter, ACK slot, ACK delimiter, seven end-of-frame bits and three interframe bits. `done` pulses for one cycle on the strobe that ends the last of them, and `busy` then falls.
- R8: `ackSeen` is set when `rxBit` is dominant while the ACK slot is being driven, and is otherwise low. It is cleared when a new frame starts. A dominant read-back outside the arbitration field never sets `arbLost`.
- R9: If `rxBit` reads dominant while a recessive identifier, SRR, IDE or RTR bit is driven, that strobe ends the frame. `arbLost` goes high, `txBit` returns recessive, `busy` falls and no `done` pulse follows.
- R10: A start request while a frame is in progress has no effect. Input changes after a frame has started do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin a frame (taken only while idle) |
| bitStrobe | input | 1 | One pulse per bit time; advances the stream |
| rxBit | input | 1 | Bus level sampled for the current bit |
| ident | input | 29 | Identifier; standard frames use bits 10:0 |
| ideFlag | input | 1 | 1 selects the extended format |
| rtrFlag | input | 1 | 1 selects a remote frame |
| dlc | input | 4 | Data length code |
| payload | input | 64 | Data bytes, first byte in bits 63:56 |
| txBit | output | 1 | Bit driven towards the bus (1 = recessive) |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of the frame |
| ackSeen | output | 1 | A dominant ACK slot was observed |
| arbLost | output | 1 | The frame stopped on lost arbitration |

## Verification
The sweep covers both formats, data and remote frames, and every DLC value, including codes above eight. A design that failed to clamp those codes would send too many bytes, and one that ignored the remote flag would send a data field in a remote frame. All-zero and all-one identifiers and payloads create long runs. These runs catch stuffing that resets its run counter after a stuff bit, that feeds stuff bits into the CRC, or that drops the stuff bit due after the last CRC bit; each of these errors shifts the rest of the stream. Separate cases force a dominant ACK slot and a dominant read-back inside the arbitration field, and pulse start with altered inputs in mid-frame. A wrong slot position, a missing abort, or a restart would each show up in the flags or in the stream.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
  localparam int CRC_W     = 15;
  localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;
  localparam int STUFF_RUN = 5;
  localparam int TRAIL_LEN = 13;
  localparam int STD_HDR   = 19;
  localparam int EXT_HDR   = 39;
  localparam int STD_ARB   = 12;
  localparam int EXT_ARB   = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_BODY, ST_CRC, ST_TRAIL} txState_t;

  typedef struct packed {
    logic load;
    logic sendBody;
    logic sendCrc;
    logic sendStuff;
    logic sendRec;
  } dpCtl_t;
endpackage

// File: rtl/can_tx_datapath.sv
module can_tx_datapath
  import can_tx_pkg::*;
#(
  parameter int MAX_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCtl_t                 ctl,
  input  logic [28:0]            ident,
  input  logic                   ideFlag,
  input  logic                   rtrFlag,
  input  logic [3:0]             dlc,
  input  logic [8*MAX_BYTES-1:0] payload,
  output logic                   txBit,
  output logic                   stuffDue
);
  localparam int PAY_W = 8 * MAX_BYTES;
  localparam int VEC_W = EXT_HDR + PAY_W;

  logic [VEC_W-1:0]   bodyReg;
  logic [CRC_W-1:0]   crcReg;
  logic [2:0]         runLen;
  logic               lastBit;
  logic [STD_HDR-1:0] stdHdr;
  logic [EXT_HDR-1:0] extHdr;
  logic [VEC_W-1:0]   loadVec;
  logic               nextBit;
  logic [CRC_W-1:0]   crcNext;

  always_comb begin
    stdHdr  = {1'b0, ident[10:0], rtrFlag, 2'b00, dlc};
    extHdr  = {1'b0, ident[28:18], 2'b11, ident[17:0], rtrFlag, 2'b00, dlc};
    loadVec = ideFlag ? {extHdr, payload}
                      : {stdHdr, payload, {(EXT_HDR-STD_HDR){1'b0}}};
  end

  always_comb begin
    nextBit = ctl.sendCrc ? crcReg[CRC_W-1] : bodyReg[VEC_W-1];
    crcNext = {crcReg[CRC_W-2:0], 1'b0} ^
              ((bodyReg[VEC_W-1] ^ crcReg[CRC_W-1]) ? CRC_POLY : '0);
  end

  assign stuffDue = (runLen == 3'(STUFF_RUN));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bodyReg <= '0;
      crcReg  <= '0;
      runLen  <= '0;
      lastBit <= 1'b1;
      txBit   <= 1'b1;
    end else if (ctl.load) begin
      bodyReg <= loadVec;
      crcReg  <= '0;
      runLen  <= '0;
      lastBit <= 1'b1;
      txBit   <= 1'b1;
    end else if (ctl.sendStuff) begin
      txBit   <= ~lastBit;
      lastBit <= ~lastBit;
      runLen  <= 3'd1;
    end else if (ctl.sendBody || ctl.sendCrc) begin
      txBit   <= nextBit;
      lastBit <= nextBit;
      runLen  <= (nextBit == lastBit) ? runLen + 3'd1 : 3'd1;
      if (ctl.sendBody) begin
        bodyReg <= {bodyReg[VEC_W-2:0], 1'b0};
        crcReg  <= crcNext;
      end else begin
        crcReg  <= {crcReg[CRC_W-2:0], 1'b0};
      end
    end else if (ctl.sendRec) begin
      txBit <= 1'b1;
    end
  end

  // R6: the run counter never passes the stuffing threshold
  p_run_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    runLen <= 3'(STUFF_RUN));
  // R6: a stuff bit is the complement of the bit before it
  p_stuff_flip_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sendStuff |=> txBit != $past(txBit));
endmodule

// File: rtl/can_tx_control.sv
module can_tx_control
  import can_tx_pkg::*;
#(
  parameter int MAX_BYTES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       bitStrobe,
  input  logic       rxBit,
  input  logic       txBit,
  input  logic       stuffDue,
  input  logic       ideFlag,
  input  logic       rtrFlag,
  input  logic [3:0] dlc,
  output dpCtl_t     ctl,
  output logic       busy,
  output logic       done,
  output logic       ackSeen,
  output logic       arbLost
);
  localparam int IDX_W = $clog2(EXT_HDR + 8 * MAX_BYTES + 1);

  txState_t          state;
  logic [IDX_W-1:0]  bitIdx;
  logic [IDX_W-1:0]  bodyLen;
  logic [IDX_W-1:0]  bodyLenNext;
  logic [IDX_W-1:0]  arbLast;
  logic [3:0]        nBytes;
  logic [3:0]        crcCnt;
  logic [3:0]        trailCnt;
  logic              isExt;
  logic              curIsBody;
  logic              arbHit;

  always_comb begin
    if (rtrFlag)                      nBytes = '0;
    else if (dlc > 4'(MAX_BYTES))     nBytes = 4'(MAX_BYTES);
    else                              nBytes = dlc;
    bodyLenNext = IDX_W'(ideFlag ? EXT_HDR : STD_HDR) + IDX_W'({nBytes, 3'b000});
    arbLast     = IDX_W'(isExt ? EXT_ARB : STD_ARB);
    arbHit      = curIsBody && (bitIdx >= IDX_W'(2)) && (bitIdx <= arbLast + IDX_W'(1))
                  && txBit && !rxBit;
  end

  always_comb begin
    ctl = '0;
    unique case (state)
      ST_IDLE:  ctl.load = startReq;
      ST_BODY:
        if (bitStrobe) begin
          if (arbHit)                  ctl.sendRec   = 1'b1;
          else if (stuffDue)           ctl.sendStuff = 1'b1;
          else if (bitIdx < bodyLen)   ctl.sendBody  = 1'b1;
          else                         ctl.sendCrc   = 1'b1;
        end
      ST_CRC:
        if (bitStrobe) begin
          if (stuffDue)                        ctl.sendStuff = 1'b1;
          else if (crcCnt < 4'(CRC_W))         ctl.sendCrc   = 1'b1;
          else                                 ctl.sendRec   = 1'b1;
        end
      ST_TRAIL: ctl.sendRec = bitStrobe;
      default:  ctl = '0;
    endcase
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitIdx    <= '0;
      bodyLen   <= '0;
      crcCnt    <= '0;
      trailCnt  <= '0;
      isExt     <= 1'b0;
      curIsBody <= 1'b0;
      done      <= 1'b0;
      ackSeen   <= 1'b0;
      arbLost   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE:
          if (startReq) begin
            state     <= ST_BODY;
            bitIdx    <= '0;
            bodyLen   <= bodyLenNext;
            isExt     <= ideFlag;
            curIsBody <= 1'b0;
            ackSeen   <= 1'b0;
            arbLost   <= 1'b0;
          end
        ST_BODY:
          if (bitStrobe) begin
            if (arbHit) begin
              arbLost <= 1'b1;
              state   <= ST_IDLE;
            end else if (stuffDue) begin
              curIsBody <= 1'b0;
            end else if (bitIdx < bodyLen) begin
              bitIdx    <= bitIdx + IDX_W'(1);
              curIsBody <= 1'b1;
            end else begin
              curIsBody <= 1'b0;
              crcCnt    <= 4'd1;
              state     <= ST_CRC;
            end
          end
        ST_CRC:
          if (bitStrobe && !stuffDue) begin
            if (crcCnt < 4'(CRC_W)) crcCnt <= crcCnt + 4'd1;
            else begin
              trailCnt <= 4'd1;
              state    <= ST_TRAIL;
            end
          end
        ST_TRAIL:
          if (bitStrobe) begin
            if (trailCnt == 4'd2 && !rxBit) ackSeen <= 1'b1;
            if (trailCnt < 4'(TRAIL_LEN)) trailCnt <= trailCnt + 4'd1;
            else begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: the line is recessive whenever no frame is running
  p_idle_recessive_r1: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_IDLE |-> txBit);
  // R7: every trailer bit is recessive
  p_trail_recessive_r7: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_TRAIL |-> txBit);
  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R8: acknowledge is only ever captured in the trailer
  p_ack_in_trailer_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackSeen) |-> $past(state) == ST_TRAIL);
  // R9: arbitration loss only arises while header bits are sent
  p_arb_in_body_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(arbLost) |-> $past(state) == ST_BODY && state == ST_IDLE);
  // R10: a start request during a frame does not reload
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && startReq) |-> !ctl.load);
endmodule

// File: rtl/can_frame_tx.sv
module can_frame_tx
  import can_tx_pkg::*;
#(
  parameter int MAX_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startReq,
  input  logic                   bitStrobe,
  input  logic                   rxBit,
  input  logic [28:0]            ident,
  input  logic                   ideFlag,
  input  logic                   rtrFlag,
  input  logic [3:0]             dlc,
  input  logic [8*MAX_BYTES-1:0] payload,
  output logic                   txBit,
  output logic                   busy,
  output logic                   done,
  output logic                   ackSeen,
  output logic                   arbLost
);
  dpCtl_t ctl;
  logic   stuffDue;

  can_tx_control #(.MAX_BYTES(MAX_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .bitStrobe(bitStrobe),
    .rxBit(rxBit), .txBit(txBit), .stuffDue(stuffDue), .ideFlag(ideFlag),
    .rtrFlag(rtrFlag), .dlc(dlc), .ctl(ctl), .busy(busy), .done(done),
    .ackSeen(ackSeen), .arbLost(arbLost)
  );

  can_tx_datapath #(.MAX_BYTES(MAX_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ident(ident), .ideFlag(ideFlag),
    .rtrFlag(rtrFlag), .dlc(dlc), .payload(payload), .txBit(txBit),
    .stuffDue(stuffDue)
  );
endmodule

// File: tb/can_frame_tx_test.sv
module can_frame_tx_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        bitStrobe = 1'b0;
  logic        forceDom = 1'b0;
  logic        rxBit;
  logic [28:0] ident = '0;
  logic        ideFlag = 1'b0;
  logic        rtrFlag = 1'b0;
  logic [3:0]  dlc = '0;
  logic [63:0] payload = '0;
  logic        txBit, busy, done, ackSeen, arbLost;

  int checks = 0;
  int errors = 0;
  logic refBits [0:255];
  int   refLen;
  int   ackIdx;

  always #2.5 clk = ~clk;
  assign rxBit = txBit & ~forceDom;

  can_frame_tx uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .bitStrobe(bitStrobe),
    .rxBit(rxBit), .ident(ident), .ideFlag(ideFlag), .rtrFlag(rtrFlag),
    .dlc(dlc), .payload(payload), .txBit(txBit), .busy(busy), .done(done),
    .ackSeen(ackSeen), .arbLost(arbLost)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) bitStrobe = 1'b1;
    @(negedge clk) bitStrobe = 1'b0;
  endtask

  // Reference stream from the requirement text (R2..R7)
  task automatic buildRef(input logic [28:0] id, input logic ide, input logic rtr,
                          input logic [3:0] code, input logic [63:0] pay);
    logic raw [0:159];
    int n = 0;
    int nb;
    logic [14:0] crc = '0;
    logic last = 1'b1;
    int run = 0;
    raw[n++] = 1'b0;
    if (ide) begin
      for (int i = 28; i >= 18; i--) raw[n++] = id[i];
      raw[n++] = 1'b1; raw[n++] = 1'b1;
      for (int i = 17; i >= 0; i--) raw[n++] = id[i];
      raw[n++] = rtr; raw[n++] = 1'b0; raw[n++] = 1'b0;
    end else begin
      for (int i = 10; i >= 0; i--) raw[n++] = id[i];
      raw[n++] = rtr; raw[n++] = 1'b0; raw[n++] = 1'b0;
    end
    for (int i = 3; i >= 0; i--) raw[n++] = code[i];
    nb = rtr ? 0 : (code > 8 ? 8 : int'(code));
    for (int i = 0; i < nb * 8; i++) raw[n++] = pay[63 - i];
    for (int i = 0; i < n; i++) begin
      logic fb = raw[i] ^ crc[14];
      crc = {crc[13:0], 1'b0};
      if (fb) crc = crc ^ 15'h4599;
    end
    for (int i = 14; i >= 0; i--) raw[n++] = crc[i];
    refLen = 0;
    for (int i = 0; i < n; i++) begin
      refBits[refLen++] = raw[i];
      if (raw[i] == last) run++; else begin run = 1; last = raw[i]; end
      if (run == 5) begin
        refBits[refLen++] = ~raw[i];
        last = ~raw[i];
        run = 1;
      end
    end
    ackIdx = refLen + 1;
    for (int i = 0; i < 13; i++) refBits[refLen++] = 1'b1;
  endtask

  task automatic runFrame(input logic [28:0] id, input logic ide, input logic rtr,
                          input logic [3:0] code, input logic [63:0] pay,
                          input bit doAck, input bit midStart);
    int bad = 0;
    int firstBad = -1;
    buildRef(id, ide, rtr, code, pay);
    @(negedge clk);
    ident = id; ideFlag = ide; rtrFlag = rtr; dlc = code; payload = pay;
    startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    for (int k = 0; k < refLen; k++) begin
      strobe();
      if (txBit !== refBits[k]) begin
        bad++;
        if (firstBad < 0) firstBad = k;
      end
      forceDom = doAck && (k == ackIdx);
      if (midStart && k == 20) begin
        // R10: change inputs and request a start mid-frame
        ident = ~id; ideFlag = ~ide; rtrFlag = ~rtr; dlc = code + 4'd3; payload = ~pay;
        startReq = 1'b1;
        @(negedge clk) startReq = 1'b0;
      end
    end
    check(bad == 0, midStart ? "R10 stream" : "R2/R3/R4/R5/R6 stream", firstBad, -1);
    strobe();
    check(done === 1'b1 && busy === 1'b0, "R7 done", int'(done), 1);
    check(ackSeen === doAck && arbLost === 1'b0, "R8 ackSeen", int'(ackSeen), int'(doAck));
    @(negedge clk);
    check(done === 1'b0, "R7 pulse width", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(txBit === 1'b1, "R1 txBit", int'(txBit), 1);
    check(busy === 1'b0 && done === 1'b0, "R1 busy/done", int'(busy), 0);
    check(ackSeen === 1'b0 && arbLost === 1'b0, "R1 flags", int'(arbLost), 0);

    // Sweep: both formats, data/remote, every DLC code
    for (int e = 0; e < 2; e++)
      for (int r = 0; r < 2; r++)
        for (int d = 0; d < 16; d++) begin
          logic [28:0] id = 29'h0ABCDE01 ^ (29'(d) * 29'h0123457) ^ (29'(r) << 7);
          logic [63:0] pay = {8{8'(d * 37 + e * 5 + 1)}} ^ 64'h0F1E2D3C4B5A6978;
          if (d == 0)  id = '0;
          if (d == 1)  id = '1;
          if (d == 8)  pay = '1;
          if (d == 9)  pay = '0;
          runFrame(id, e[0], r[0], 4'(d), pay, d[0], 1'b0);
        end

    // R10: mid-frame start with altered inputs, frame unchanged
    runFrame(29'h1555AAAA, 1'b1, 1'b0, 4'd5, 64'h0123456789ABCDEF, 1'b1, 1'b1);

    // R9: dominant read-back on recessive identifier bit 8 of 0x5A5 (stream index 3)
    buildRef(29'h5A5, 1'b0, 1'b0, 4'd2, 64'hFFFF0000_00000000);
    @(negedge clk);
    ident = 29'h5A5; ideFlag = 1'b0; rtrFlag = 1'b0; dlc = 4'd2; payload = 64'hFFFF0000_00000000;
    startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    for (int k = 0; k < 4; k++) strobe();
    check(txBit === 1'b1 && refBits[3] === 1'b1, "R9 setup", int'(txBit), 1);
    forceDom = 1'b1;
    strobe();
    forceDom = 1'b0;
    check(arbLost === 1'b1, "R9 arbLost", int'(arbLost), 1);
    check(busy === 1'b0 && txBit === 1'b1, "R9 idle after loss", int'(busy), 0);
    begin
      bit sawDone = 1'b0;
      for (int k = 0; k < 30; k++) begin
        strobe();
        if (done === 1'b1 || txBit !== 1'b1) sawDone = 1'b1;
      end
      check(!sawDone, "R9 no completion", int'(sawDone), 0);
    end

    // R8: a following normal frame clears arbLost and ackSeen on start
    runFrame(29'h00000123, 1'b0, 1'b1, 4'd7, 64'h0, 1'b0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule